// File: doc/BRIEF.md
# Debug Watchpoint and Halt Unit

This block sits beside a processor core and watches every bus cycle. Two programmable comparators test the cycle's address, data and control fields against stored values, where each stored bit can be made a don't-care. The two comparators can act alone, in sequence (the second counts only after the first has fired), or together as a window that needs both. A catch register can also trap instruction fetches from selected exception vectors. Any trigger, or the external debug-request and breakpoint pins, moves the core from running into a halted debug state. A restart command, written through the configuration port, releases it.

The bus side only observes: `bus_valid` marks a cycle to compare, and nothing is pushed back, so there is no ready signal and no back-pressure. The configuration port is a plain single-cycle write strobe with a combinational read mux. The halt outputs are level signals that the core's fetch logic obeys.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset the unit is running (`fetch_en`=1, `dbg_ack`=0, `hit`=0), every comparator is disabled, and every register reads 0.
- R2: Comparator n (register base n*8: +0 address value, +1 address mask, +2 data value, +3 data mask, +4 control value, +5 control mask, +6 enable bit 0) matches a cycle with `bus_valid` high when it is enabled and every address, data and control bit either equals its stored bit or has mask bit 1. The control field is {fetch, write, size[1:0]}, from bit 3 down to bit 0.
- R3: With mode register (address 16) at 0, a match on either comparator drives `hit` high on the edge after the bus cycle and enters the halted state on that same edge.
- R4: With mode bit 0 set and bit 1 clear, comparator 1 triggers only if comparator 0 has matched in an earlier cycle. Comparator 0 alone never triggers. This armed condition is cleared when comparator 1 fires or when bit 1 is written to the command register (address 18).
- R5: With mode bit 1 set, whatever bit 0 holds, a trigger needs both comparators to match in the same bus cycle.
- R6: Vector catch register (address 17) bit i traps a fetch cycle at byte address i*4. The trap gives `hit` and a halt, like R3. A non-fetch cycle, a disabled bit, or an address beyond the vector table does nothing.
- R7: `dbg_req` and `brk_in` each pass through two flops. The unit halts on the third edge after the pin rises. These pins do not assert `hit`.
- R8: `dbg_ack` is high exactly in the halted state and `fetch_en` exactly in the running state. The two are never high together.
- R9: Writing bit 0 of the command register while halted with no trigger or synchronized pin pending gives one cycle with both `dbg_ack` and `fetch_en` low, then running. With a trigger pending the write is ignored. Outside the halted state the write has no effect.
- R10: Status register (address 19) reads {cause[2:0] at bits 7:5 (external, vector, watchpoint; latched on entry to halt), armed at bit 4, synchronized brk at bit 3, synchronized request at bit 2, state at bits 1:0 (0 running, 1 halted, 2 restarting)}.
- R11: Every comparator, mode and vector-catch register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | AW | Bus cycle address |
| bus_data | input | DW | Bus cycle data |
| bus_write | input | 1 | Cycle is a write |
| bus_size | input | 2 | Access size code |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| dbg_req | input | 1 | Asynchronous debug request |
| brk_in | input | 1 | Asynchronous external breakpoint |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register index |
| cfg_wdata | input | RW | Configuration write data |
| cfg_rdata | output | RW | Readback of the indexed register |
| hit | output | 1 | Watchpoint or vector trigger seen last cycle |
| dbg_ack | output | 1 | Core is in debug state |
| fetch_en | output | 1 | Core may fetch instructions |

## Verification
A bus cycle presented in cycle n has its effect on `hit`, `dbg_ack` and `fetch_en` after edge n+1, and a restart command has its effect after n+1 (gap) and n+2 (running). A pin change reaches the state after edge n+3. The driver stamps each expected output triple with the exact cycle it is due, and a monitor samples a quarter period after each rising edge and compares only the items due in that cycle. An item found late counts as a failure. Register readback is combinational, so it is checked 1 ns after the index is set at a falling edge.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  localparam int REG_AW  = 5;
  localparam int NCMP    = 2;
  localparam int FLD_W   = 3;
  localparam int SZW     = 2;
  localparam int CIDX_W  = $clog2(NCMP);

  localparam logic [FLD_W-1:0] F_AVAL = 3'd0;
  localparam logic [FLD_W-1:0] F_AMSK = 3'd1;
  localparam logic [FLD_W-1:0] F_DVAL = 3'd2;
  localparam logic [FLD_W-1:0] F_DMSK = 3'd3;
  localparam logic [FLD_W-1:0] F_CVAL = 3'd4;
  localparam logic [FLD_W-1:0] F_CMSK = 3'd5;
  localparam logic [FLD_W-1:0] F_EN   = 3'd6;

  localparam logic [REG_AW-1:0] REG_MODE = 5'd16;
  localparam logic [REG_AW-1:0] REG_VCAT = 5'd17;
  localparam logic [REG_AW-1:0] REG_CMD  = 5'd18;
  localparam logic [REG_AW-1:0] REG_STAT = 5'd19;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_RESUME = 2'd2
  } dbg_state_e;
endpackage

// File: rtl/dwu_sync.sv
module dwu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  // R7: two flops between pin and use
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/dwu_cmp.sv
module dwu_cmp #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          en,
  input  logic          valid,
  input  logic [AW-1:0] a_val,
  input  logic [AW-1:0] a_msk,
  input  logic [DW-1:0] d_val,
  input  logic [DW-1:0] d_msk,
  input  logic [CW-1:0] c_val,
  input  logic [CW-1:0] c_msk,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] ctl,
  output logic          match
);
  logic a_ok, d_ok, c_ok;

  // R2: equal-or-ignored on every bit of every field
  assign a_ok  = &(~(a_val ^ addr) | a_msk);
  assign d_ok  = &(~(d_val ^ data) | d_msk);
  assign c_ok  = &(~(c_val ^ ctl)  | c_msk);
  assign match = en & valid & a_ok & d_ok & c_ok;
endmodule

// File: rtl/dwu_halt_fsm.sv
module dwu_halt_fsm
  import dwu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_watch,
  input  logic       evt_vec,
  input  logic       evt_ext,
  input  logic       restart_req,
  output dbg_state_e state_q,
  output logic [2:0] cause_q
);
  dbg_state_e state_d;
  logic       pending;

  assign pending = evt_watch | evt_vec | evt_ext;

  // R9: restart leaves halt only when nothing is pending
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (pending) state_d = ST_HALT;
      ST_HALT:   if (restart_req && !pending) state_d = ST_RESUME;
      ST_RESUME: state_d = pending ? ST_HALT : ST_RUN;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_HALT && pending) cause_q <= {evt_ext, evt_vec, evt_watch};
    end
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dwu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RW   = 32,
  parameter int NVEC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_write,
  input  logic [SZW-1:0]    bus_size,
  input  logic              bus_fetch,
  input  logic              dbg_req,
  input  logic              brk_in,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [RW-1:0]     cfg_wdata,
  output logic [RW-1:0]     cfg_rdata,
  output logic              hit,
  output logic              dbg_ack,
  output logic              fetch_en
);
  localparam int CW  = SZW + 2;
  localparam int VIW = $clog2(NVEC);

  logic [AW-1:0] aval_q [NCMP];
  logic [AW-1:0] amsk_q [NCMP];
  logic [DW-1:0] dval_q [NCMP];
  logic [DW-1:0] dmsk_q [NCMP];
  logic [CW-1:0] cval_q [NCMP];
  logic [CW-1:0] cmsk_q [NCMP];
  logic [NCMP-1:0] en_q;
  logic [1:0]      mode_q;
  logic [NVEC-1:0] vc_q;
  logic            armed_q;
  logic            hit_q;

  logic [NCMP-1:0] cmp_hit;
  logic [CW-1:0]   bus_ctl;
  logic            cmp_sel;
  logic [CIDX_W-1:0] cidx;
  logic [FLD_W-1:0]  fld;
  logic            req_s, brk_s;
  logic            chain_on, range_on, watch_evt, vec_evt;
  logic            restart_cmd, clear_cmd;
  dbg_state_e      state_q;
  logic [2:0]      cause_q;

  assign bus_ctl = {bus_fetch, bus_write, bus_size};
  assign cmp_sel = (cfg_addr[REG_AW-1] == 1'b0);
  assign cidx    = cfg_addr[FLD_W +: CIDX_W];
  assign fld     = cfg_addr[FLD_W-1:0];

  // R11: configuration storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCMP; i++) begin
        aval_q[i] <= '0; amsk_q[i] <= '0;
        dval_q[i] <= '0; dmsk_q[i] <= '0;
        cval_q[i] <= '0; cmsk_q[i] <= '0;
      end
      en_q   <= '0;
      mode_q <= '0;
      vc_q   <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NCMP; i++) begin
        if (cmp_sel && cidx == CIDX_W'(i)) begin
          case (fld)
            F_AVAL:  aval_q[i] <= cfg_wdata[AW-1:0];
            F_AMSK:  amsk_q[i] <= cfg_wdata[AW-1:0];
            F_DVAL:  dval_q[i] <= cfg_wdata[DW-1:0];
            F_DMSK:  dmsk_q[i] <= cfg_wdata[DW-1:0];
            F_CVAL:  cval_q[i] <= cfg_wdata[CW-1:0];
            F_CMSK:  cmsk_q[i] <= cfg_wdata[CW-1:0];
            F_EN:    en_q[i]   <= cfg_wdata[0];
            default: ;
          endcase
        end
      end
      if (cfg_addr == REG_MODE) mode_q <= cfg_wdata[1:0];
      if (cfg_addr == REG_VCAT) vc_q   <= cfg_wdata[NVEC-1:0];
    end
  end

  assign restart_cmd = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[0];
  assign clear_cmd   = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[1];

  // R2: one comparator per unit
  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    dwu_cmp #(.AW(AW), .DW(DW), .CW(CW)) u_cmp (
      .en(en_q[gi]), .valid(bus_valid),
      .a_val(aval_q[gi]), .a_msk(amsk_q[gi]),
      .d_val(dval_q[gi]), .d_msk(dmsk_q[gi]),
      .c_val(cval_q[gi]), .c_msk(cmsk_q[gi]),
      .addr(bus_addr), .data(bus_data), .ctl(bus_ctl),
      .match(cmp_hit[gi])
    );
  end

  // R4, R5: coupling of the two comparators
  assign range_on = mode_q[1];
  assign chain_on = mode_q[0] & ~mode_q[1];

  always_comb begin
    if (range_on)      watch_evt = cmp_hit[0] & cmp_hit[1];
    else if (chain_on) watch_evt = cmp_hit[1] & armed_q;
    else               watch_evt = |cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      armed_q <= 1'b0;
    else if (clear_cmd || !chain_on) armed_q <= 1'b0;
    else if (cmp_hit[0])             armed_q <= 1'b1;
    else if (watch_evt)              armed_q <= 1'b0;
  end

  // R6: vector catch on fetches inside the vector table
  assign vec_evt = bus_valid && bus_fetch && (bus_addr[1:0] == 2'b00)
                && (bus_addr[AW-1:VIW+2] == '0) && vc_q[bus_addr[VIW+1:2]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= watch_evt | vec_evt;
  end

  dwu_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({brk_in, dbg_req}), .q({brk_s, req_s})
  );

  dwu_halt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .evt_watch(watch_evt), .evt_vec(vec_evt), .evt_ext(req_s | brk_s),
    .restart_req(restart_cmd),
    .state_q(state_q), .cause_q(cause_q)
  );

  // R8: outputs decoded from the state
  assign hit      = hit_q;
  assign dbg_ack  = (state_q == ST_HALT);
  assign fetch_en = (state_q == ST_RUN);

  // R10, R11: readback mux
  always_comb begin
    cfg_rdata = '0;
    if (cmp_sel) begin
      case (fld)
        F_AVAL:  cfg_rdata = RW'(aval_q[cidx]);
        F_AMSK:  cfg_rdata = RW'(amsk_q[cidx]);
        F_DVAL:  cfg_rdata = RW'(dval_q[cidx]);
        F_DMSK:  cfg_rdata = RW'(dmsk_q[cidx]);
        F_CVAL:  cfg_rdata = RW'(cval_q[cidx]);
        F_CMSK:  cfg_rdata = RW'(cmsk_q[cidx]);
        F_EN:    cfg_rdata = RW'(en_q[cidx]);
        default: cfg_rdata = '0;
      endcase
    end else begin
      case (cfg_addr)
        REG_MODE: cfg_rdata = RW'(mode_q);
        REG_VCAT: cfg_rdata = RW'(vc_q);
        REG_STAT: cfg_rdata = RW'({cause_q, armed_q, brk_s, req_s, 2'(state_q)});
        default:  cfg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dwu_chk.sv
module dwu_chk
  import dwu_pkg::*;
#(
  parameter int RW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_req,
  input logic              req_s,
  input logic              cfg_we,
  input logic [REG_AW-1:0] cfg_addr,
  input logic [RW-1:0]     cfg_wdata,
  input logic              hit,
  input logic              dbg_ack,
  input logic              fetch_en
);
  logic restart_seen;
  assign restart_seen = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[0];

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_ack && fetch_en));

  a_r3_hit_halts: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> dbg_ack);

  a_r7_two_flops: assert property (@(posedge clk) disable iff (!rst_n)
    req_s |-> $past(dbg_req, 2));

  a_r9_leave_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_ack) |-> $past(restart_seen));

  a_r9_gap_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_en) |-> !$past(dbg_ack));
endmodule

bind dbg_watch_unit dwu_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .req_s(req_s),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .hit(hit), .dbg_ack(dbg_ack), .fetch_en(fetch_en)
);

// File: tb/sim_dbg_watch_unit.sv
`timescale 1ns/1ps
module sim_dbg_watch_unit;
  localparam int R1 = 1, R2 = 2, R3 = 3, R4 = 4, R5 = 5, R6 = 6;
  localparam int R7 = 7, R8 = 8, R9 = 9, R10 = 10, R11 = 11;
  localparam logic [2:0] RUN3 = 3'b100, HALT3 = 3'b010, HIT3 = 3'b011, GAP3 = 3'b000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_fetch = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [1:0]  bus_size = '0;
  logic        dbg_req = 1'b0, brk_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        hit, dbg_ack, fetch_en;

  always #10 clk = ~clk;

  dbg_watch_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_write(bus_write), .bus_size(bus_size),
    .bus_fetch(bus_fetch), .dbg_req(dbg_req), .brk_in(brk_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hit(hit), .dbg_ack(dbg_ack), .fetch_en(fetch_en)
  );

  typedef struct { int due; int rq; logic [2:0] exp; } item_t;
  item_t sb_q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Monitor: a quarter period after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        it = sb_q.pop_front();
        n_chk++;
        if (it.due != cyc || {fetch_en, dbg_ack, hit} !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d cycle %0d: {fetch_en,dbg_ack,hit} actual %b expected %b (due %0d)",
                   it.rq, cyc, {fetch_en, dbg_ack, hit}, it.exp, it.due);
        end
      end
    end
  end

  task automatic push(input int dly, input int rq, input logic [2:0] e);
    item_t it;
    it.due = cyc + dly; it.rq = rq; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input int rq);
    cfg_addr = a;
    #1;
    n_chk++;
    if (cfg_rdata !== e) begin
      n_fail++;
      $display("FAIL R%0d readback reg %0d: actual %h expected %h", rq, a, cfg_rdata, e);
    end
  endtask

  task automatic bus_op(input logic [31:0] a, input logic [31:0] d, input logic w,
                        input logic [1:0] sz, input logic f, input logic [2:0] e, input int rq);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_write = w; bus_size = sz; bus_fetch = f;
    push(1, rq, e);
    tick();
    bus_valid = 1'b0;
  endtask

  task automatic restart_ok(input int rq);
    push(1, rq, GAP3);
    push(2, rq, RUN3);
    wr(5'd18, 32'h1);
    tick();
  endtask

  task automatic restart_blocked(input int rq);
    push(1, rq, HALT3);
    push(2, rq, HALT3);
    wr(5'd18, 32'h1);
    tick();
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1: reset state
    push(1, R1, RUN3);
    rd_chk(5'd19, 32'h0, R1);
    rd_chk(5'd0, 32'h0, R1);
    tick();

    // R11: comparator 0 setup and readback
    wr(5'd0, 32'h0000_1000);
    rd_chk(5'd0, 32'h0000_1000, R11);
    wr(5'd1, 32'h0000_000F);
    wr(5'd3, 32'hFFFF_FFFF);
    wr(5'd4, 32'h6);
    wr(5'd5, 32'h0);
    wr(5'd6, 32'h1);
    rd_chk(5'd4, 32'h6, R11);

    // R2: near misses on control, address and direction
    bus_op(32'h1004, 32'h0, 1'b1, 2'd1, 1'b0, RUN3, R2);
    bus_op(32'h1110, 32'h0, 1'b1, 2'd2, 1'b0, RUN3, R2);
    bus_op(32'h1004, 32'h0, 1'b0, 2'd2, 1'b0, RUN3, R2);
    // R3: match under the low-nibble mask
    bus_op(32'h100C, 32'h5, 1'b1, 2'd2, 1'b0, HIT3, R3);
    rd_chk(5'd19, 32'h21, R10);
    restart_ok(R9);

    // Comparator 1 on data
    wr(5'd8, 32'h2000); wr(5'd9, 32'h0);
    wr(5'd10, 32'hDEAD_BEEF); wr(5'd11, 32'h0);
    wr(5'd13, 32'hF); wr(5'd14, 32'h1);
    rd_chk(5'd10, 32'hDEAD_BEEF, R11);
    bus_op(32'h2000, 32'hDEAD_BEEE, 1'b0, 2'd2, 1'b0, RUN3, R2);
    bus_op(32'h2000, 32'hDEAD_BEEF, 1'b0, 2'd2, 1'b0, HIT3, R3);
    restart_ok(R9);

    // R4: chained
    wr(5'd16, 32'h1);
    rd_chk(5'd16, 32'h1, R11);
    bus_op(32'h2000, 32'hDEAD_BEEF, 1'b0, 2'd2, 1'b0, RUN3, R4);
    bus_op(32'h1000, 32'h0, 1'b1, 2'd2, 1'b0, RUN3, R4);
    rd_chk(5'd19, 32'h30, R10);
    bus_op(32'h2000, 32'hDEAD_BEEF, 1'b0, 2'd2, 1'b0, HIT3, R4);
    restart_ok(R9);
    rd_chk(5'd19, 32'h20, R4);
    bus_op(32'h1000, 32'h0, 1'b1, 2'd2, 1'b0, RUN3, R4);
    wr(5'd18, 32'h2);
    rd_chk(5'd19, 32'h20, R4);
    bus_op(32'h2000, 32'hDEAD_BEEF, 1'b0, 2'd2, 1'b0, RUN3, R4);

    // R5: ranged, with chain bit also set
    wr(5'd16, 32'h3);
    wr(5'd0, 32'h3000); wr(5'd1, 32'h0000_0FFF);
    wr(5'd4, 32'h0); wr(5'd5, 32'hF);
    wr(5'd8, 32'h0); wr(5'd9, 32'hFFFF_F0FF); wr(5'd11, 32'hFFFF_FFFF);
    bus_op(32'h3500, 32'h0, 1'b0, 2'd2, 1'b0, RUN3, R5);
    bus_op(32'h0010, 32'h0, 1'b0, 2'd2, 1'b0, RUN3, R5);
    bus_op(32'h3040, 32'h0, 1'b0, 2'd2, 1'b0, HIT3, R5);
    restart_ok(R9);

    // R6: vector catch on vector 2
    wr(5'd16, 32'h0); wr(5'd6, 32'h0); wr(5'd14, 32'h0);
    wr(5'd17, 32'h4);
    rd_chk(5'd17, 32'h4, R11);
    bus_op(32'h04, 32'h0, 1'b0, 2'd2, 1'b1, RUN3, R6);
    bus_op(32'h08, 32'h0, 1'b0, 2'd2, 1'b0, RUN3, R6);
    bus_op(32'h28, 32'h0, 1'b0, 2'd2, 1'b1, RUN3, R6);
    bus_op(32'h08, 32'h0, 1'b0, 2'd2, 1'b1, HIT3, R6);
    rd_chk(5'd19, 32'h41, R10);
    restart_ok(R9);

    // R7: debug request through the synchronizer
    dbg_req = 1'b1;
    push(1, R7, RUN3); push(2, R7, RUN3); push(3, R7, HALT3);
    repeat (3) tick();
    rd_chk(5'd19, 32'h85, R10);
    restart_blocked(R9);
    dbg_req = 1'b0;
    repeat (2) tick();
    restart_ok(R9);

    // R7: breakpoint pin
    brk_in = 1'b1;
    push(1, R7, RUN3); push(2, R7, RUN3); push(3, R7, HALT3);
    repeat (3) tick();
    rd_chk(5'd19, 32'h89, R10);
    brk_in = 1'b0;
    repeat (2) tick();
    restart_ok(R9);

    // R9, R8: restart while running has no effect
    push(1, R8, RUN3); push(2, R9, RUN3);
    wr(5'd18, 32'h1);
    tick();
    rd_chk(5'd19, 32'h80, R9);

    repeat (3) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule